// File: doc/BRIEF.md
# Single-Cycle Minimal Processor Core

This block is a small 32-bit processor that completes one whole instruction on every rising clock edge. In a single cycle it fetches, decodes, executes and writes back, with no pipeline. A word-addressed program counter reads a 256-word instruction store. A combinational decoder splits the instruction into its fields, sign-extends the immediate and drives the control lines. A two-operand adder/subtractor produces either a register result or a data-memory address. The result, or the word loaded from the 256-word data store, returns to a 16-entry register file in which entry 0 is fixed at zero.

The program is written into the instruction store through a load port, normally while reset is held. After reset is released, the core runs freely, one instruction per clock. The program counter, every register and every data-memory word can be read at any time through combinational debug read ports. This lets a checker compare the full architectural state against a reference model after each clock. The instruction set has six defined operations: no-op, register add, register subtract, add-immediate, word load and word store. Control transfer, traps and byte addressing are outside its scope.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, all registers become 0 and every data-memory word reads back as 0 from then on until it is stored to. No register or memory write takes effect during reset.
- R2: Register 0 always reads 0. An instruction whose destination field is 0 changes no register.
- R3: Instruction bit fields are: [31:26] operation, [25:22] destination, [21:18] first source, [17:14] second source, [13:0] immediate. The immediate is two's complement and is sign-extended to 32 bits before use, so -8192 (0x2000) becomes 0xFFFFE000.
- R4: Operation 1 writes src1+src2 and operation 2 writes src1-src2 to the destination, both modulo 2^32.
- R5: Operation 3 writes src1 plus the extended immediate to the destination.
- R6: Operation 5 writes the second source register's value to the data word addressed by bits [7:0] of (src1 + extended immediate). It writes no register.
- R7: Operation 4 writes the data word addressed by bits [7:0] of (src1 + extended immediate) to the destination. The value is the one held before that clock edge.
- R8: With `rst` low, the program counter increases by exactly 1 on every clock and wraps from 255 to 0.
- R9: Operation 0 and operations 6 to 63 change no register and no data-memory word.
- R10: The eight words 00000000, 0c400005, 0c800003, 04c48000, 1400c000, 11000000, 09508000, 00000000, run from address 0, leave x1=5, x2=3, x3=8, x4=8, x5=5 and data word 0 equal to 8.
- R11: When `prog_we` is high at a rising edge, `prog_data` is stored at instruction address `prog_addr`. Reloading and resetting makes the core run the new program.
- R12: For any mix of instructions, the architectural state after each clock equals that of a sequential interpreter of R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 8 | Instruction store write address |
| prog_data | input | 32 | Instruction word to store |
| pc_o | output | 8 | Current program counter |
| dbg_reg_sel | input | 4 | Register index for debug read |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_addr | input | 8 | Data-memory address for debug read |
| dbg_mem_data | output | 32 | Value of the selected data word |

## Verification
Every instruction retires in the cycle it is fetched, so a fault in decode, operand selection or writeback shows up as a wrong register or data word right after the edge that executed it. A corrupted program counter shows up at `pc_o` on the next edge. The bench compares the whole register file, all 256 data words and the program counter after every clock. Any divergence is therefore caught within one instruction and attributed to the instruction that caused it. A fault that the stored state would otherwise hide, such as a stray write to register 0, is caught the same cycle through the debug read ports.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;
  localparam int RIW  = 4;
  localparam int NREG = 1 << RIW;

  // Field positions, derived from the top of the word downward
  localparam int OP_LSB  = XLEN - OPW;
  localparam int RD_LSB  = OP_LSB - RIW;
  localparam int RS1_LSB = RD_LSB - RIW;
  localparam int RS2_LSB = RS1_LSB - RIW;
  localparam int IMMW    = RS2_LSB;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 6'd0,
    OP_ADD   = 6'd1,
    OP_SUB   = 6'd2,
    OP_ADDI  = 6'd3,
    OP_LOAD  = 6'd4,
    OP_STORE = 6'd5
  } op_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_write;
    logic    alu_src_imm;
    alu_op_e alu_op;
    logic    mem_to_reg;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl,
  output logic [RIW-1:0]  rd,
  output logic [RIW-1:0]  rs1,
  output logic [RIW-1:0]  rs2,
  output logic [XLEN-1:0] imm
);
  op_e opc;

  assign opc = op_e'(instr[XLEN-1:OP_LSB]);
  assign rd  = instr[RD_LSB +: RIW];
  assign rs1 = instr[RS1_LSB +: RIW];
  assign rs2 = instr[RS2_LSB +: RIW];
  assign imm = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opc)
      OP_ADD:   ctl.reg_write = 1'b1;
      OP_SUB: begin
        ctl.reg_write = 1'b1;
        ctl.alu_op    = ALU_SUB;
      end
      OP_ADDI: begin
        ctl.reg_write   = 1'b1;
        ctl.alu_src_imm = 1'b1;
      end
      OP_LOAD: begin
        ctl.reg_write   = 1'b1;
        ctl.alu_src_imm = 1'b1;
        ctl.mem_to_reg  = 1'b1;
      end
      OP_STORE: begin
        ctl.mem_write   = 1'b1;
        ctl.alu_src_imm = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_reg,
  input  logic [W-1:0] b_imm,
  input  logic         sel_imm,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  logic [W-1:0] b;

  assign b = sel_imm ? b_imm : b_reg;

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int NRD = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [DW-1:0]           wd,
  input  logic [NRD-1:0][AW-1:0]  ra,
  output logic [NRD-1:0][DW-1:0]  rdat
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] q [DEPTH];
  logic          wr_ok;

  // Entry 0 is never written, so it keeps its reset value of zero
  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (wr_ok) begin
      q[wa] <= wd;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdat[k] = q[ra[k]];
  end

  AST_X0_HOLD: assert property (@(posedge clk) disable iff (rst) q[0] == '0); // R2
  AST_REG_LAND: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> q[$past(wa)] == $past(wd)); // R4
endmodule

// File: rtl/core_wordmem.sv
module core_wordmem #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NRD   = 1,
  parameter bit CLEAR = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Storage array has no reset so it maps onto memory primitives
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  if (CLEAR) begin : g_clear
    // One flag per word marks it as written since reset
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else if (we) vld[waddr] <= 1'b1;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rdata[k] = vld[raddr[k]] ? mem[raddr[k]] : '0;
    end

    AST_MEM_FLAG: assert property (@(posedge clk) disable iff (rst)
      we |=> vld[$past(waddr)]); // R6
  end else begin : g_plain
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rdata[k] = mem[raddr[k]];
    end
  end

  AST_MEM_LAND: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata)); // R6
endmodule

// File: rtl/mini_core.sv
module mini_core
  import core_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]    prog_data,
  output logic [IMEM_AW-1:0] pc_o,
  input  logic [RIW-1:0]     dbg_reg_sel,
  output logic [XLEN-1:0]    dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data
);
  logic [IMEM_AW-1:0] pc;
  logic [XLEN-1:0]    instr;
  ctrl_t              ctl;
  logic [RIW-1:0]     rd, rs1, rs2;
  logic [XLEN-1:0]    imm, src1, src2, alu_y, ld_word, wb;

  logic [0:0][IMEM_AW-1:0] im_ra;
  logic [0:0][XLEN-1:0]    im_rd;
  logic [2:0][RIW-1:0]     rf_ra;
  logic [2:0][XLEN-1:0]    rf_rd;
  logic [1:0][DMEM_AW-1:0] dm_ra;
  logic [1:0][XLEN-1:0]    dm_rd;

  // Program counter: one word per clock, natural wrap
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + 1'b1;
  end
  assign pc_o = pc;

  AST_PC_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(pc) + 1'b1); // R8

  // Fetch
  assign im_ra[0] = pc;
  assign instr    = im_rd[0];

  core_wordmem #(.AW(IMEM_AW), .DW(XLEN), .NRD(1), .CLEAR(1'b0)) u_imem (
    .clk(clk), .rst(rst), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(im_ra), .rdata(im_rd)
  );

  // Decode
  core_decode u_dec (
    .instr(instr), .ctl(ctl), .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm)
  );

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (instr[XLEN-1:OP_LSB] > OPW'(5) || instr[XLEN-1:OP_LSB] == '0)
      |-> !ctl.reg_write && !ctl.mem_write); // R9
  AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
    !(ctl.reg_write && ctl.mem_write)); // R6

  // Register file: port 0/1 operands, port 2 debug
  assign rf_ra[0]     = rs1;
  assign rf_ra[1]     = rs2;
  assign rf_ra[2]     = dbg_reg_sel;
  assign src1         = rf_rd[0];
  assign src2         = rf_rd[1];
  assign dbg_reg_data = rf_rd[2];

  core_regfile #(.AW(RIW), .DW(XLEN), .NRD(3)) u_rf (
    .clk(clk), .rst(rst), .we(ctl.reg_write && !rst), .wa(rd), .wd(wb),
    .ra(rf_ra), .rdat(rf_rd)
  );

  // Execute
  core_alu #(.W(XLEN)) u_alu (
    .a(src1), .b_reg(src2), .b_imm(imm), .sel_imm(ctl.alu_src_imm),
    .op(ctl.alu_op), .y(alu_y)
  );

  // Data memory: port 0 load path, port 1 debug
  assign dm_ra[0]     = alu_y[DMEM_AW-1:0];
  assign dm_ra[1]     = dbg_mem_addr;
  assign ld_word      = dm_rd[0];
  assign dbg_mem_data = dm_rd[1];

  core_wordmem #(.AW(DMEM_AW), .DW(XLEN), .NRD(2), .CLEAR(1'b1)) u_dmem (
    .clk(clk), .rst(rst), .we(ctl.mem_write && !rst),
    .waddr(alu_y[DMEM_AW-1:0]), .wdata(src2),
    .raddr(dm_ra), .rdata(dm_rd)
  );

  // Writeback
  assign wb = ctl.mem_to_reg ? ld_word : alu_y;
endmodule

// File: tb/sim_mini_core.sv
module sim_mini_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 8_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [7:0]  pc_o;
  logic [3:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;
  logic [7:0]  dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] prog  [256];
  logic [31:0] ref_r [16];
  logic [31:0] ref_m [256];
  logic [7:0]  ref_pc;

  mini_core u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc_o(pc_o), .dbg_reg_sel(dbg_reg_sel),
    .dbg_reg_data(dbg_reg_data), .dbg_mem_addr(dbg_mem_addr),
    .dbg_mem_data(dbg_mem_data)
  );

  function automatic logic [31:0] enc(int op, int rd, int rs1, int rs2, int imm);
    logic [13:0] i14;
    i14 = 14'(imm);
    return {6'(op), 4'(rd), 4'(rs1), 4'(rs2), i14};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    clk = 1'b1;
    #(CLK_PERIOD/2);
    clk = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic peek_reg(int idx, output logic [31:0] v);
    dbg_reg_sel = 4'(idx);
    #1;
    v = dbg_reg_data;
  endtask

  task automatic peek_mem(int a, output logic [31:0] v);
    dbg_mem_addr = 8'(a);
    #1;
    v = dbg_mem_data;
  endtask

  // Sequential interpreter of the instruction set
  task automatic ref_step();
    logic [31:0] w, a, b, s, ea, res;
    logic [5:0]  op;
    logic [3:0]  rd;
    logic        wr;
    w  = prog[ref_pc];
    op = w[31:26];
    rd = w[25:22];
    a  = ref_r[w[21:18]];
    b  = ref_r[w[17:14]];
    s  = {{18{w[13]}}, w[13:0]};
    ea = a + s;
    wr = 1'b1;
    res = '0;
    case (op)
      6'd1: res = a + b;
      6'd2: res = a - b;
      6'd3: res = ea;
      6'd4: res = ref_m[ea[7:0]];
      6'd5: begin ref_m[ea[7:0]] = b; wr = 1'b0; end
      default: wr = 1'b0;
    endcase
    if (wr && rd != 0) ref_r[rd] = res;
    ref_pc = ref_pc + 8'd1;
  endtask

  task automatic check_state(string tag);
    logic [31:0] v;
    chk("R8", "pc", {24'd0, pc_o}, {24'd0, ref_pc});
    for (int i = 0; i < 16; i++) begin
      peek_reg(i, v);
      chk(tag, $sformatf("x%0d", i), v, ref_r[i]);
    end
    for (int i = 0; i < 256; i++) begin
      peek_mem(i, v);
      chk(tag, $sformatf("mem[%0d]", i), v, ref_m[i]);
    end
  endtask

  // Load the program array while reset is held, then release
  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      prog_addr = 8'(i);
      prog_data = prog[i];
      prog_we   = 1'b1;
      tick();
    end
    prog_we = 1'b0;
    tick();
    for (int i = 0; i < 16; i++) ref_r[i] = '0;
    for (int i = 0; i < 256; i++) ref_m[i] = '0;
    ref_pc = '0;
    rst = 1'b0;
    check_state("R1");
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) begin
      ref_step();
      tick();
      check_state(tag);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = '0;
  endtask

  initial begin
    #(WATCHDOG);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0C0E));

    // R10 directed program, also R11 load port
    clear_prog();
    prog[1] = 32'h0c400005; prog[2] = 32'h0c800003; prog[3] = 32'h04c48000;
    prog[4] = 32'h1400c000; prog[5] = 32'h11000000; prog[6] = 32'h09508000;
    load_and_reset();
    run(8, "R10");
    peek_reg(1, v); chk("R10", "x1", v, 32'd5);
    peek_reg(2, v); chk("R10", "x2", v, 32'd3);
    peek_reg(3, v); chk("R10", "x3", v, 32'd8);
    peek_reg(4, v); chk("R10", "x4", v, 32'd8);
    peek_reg(5, v); chk("R10", "x5", v, 32'd5);
    peek_mem(0, v); chk("R10", "mem[0]", v, 32'd8);

    // R3 / R5 immediate extension and add-immediate
    clear_prog();
    prog[0] = enc(3, 1, 0, 0, -1);
    prog[1] = enc(3, 2, 0, 0, -8192);
    prog[2] = enc(3, 3, 0, 0, 8191);
    prog[3] = enc(3, 4, 1, 0, 1);
    prog[4] = enc(3, 5, 3, 0, -8191);
    load_and_reset();
    run(6, "R5");
    peek_reg(2, v); chk("R3", "x2 min imm", v, 32'hFFFFE000);
    peek_reg(3, v); chk("R3", "x3 max imm", v, 32'h00001FFF);
    peek_reg(4, v); chk("R5", "x4", v, 32'd0);
    peek_reg(5, v); chk("R5", "x5", v, 32'd0);
    peek_reg(1, v); chk("R11", "new program ran", v, 32'hFFFFFFFF);

    // R2 writes to register 0 are dropped
    clear_prog();
    prog[0] = enc(3, 0, 0, 0, 7);
    prog[1] = enc(3, 1, 0, 0, 4);
    prog[2] = enc(1, 0, 1, 1, 0);
    prog[3] = enc(1, 2, 0, 0, 0);
    prog[4] = enc(4, 0, 0, 0, 0);
    load_and_reset();
    run(6, "R2");
    peek_reg(0, v); chk("R2", "x0", v, 32'd0);
    peek_reg(2, v); chk("R2", "x2 from x0", v, 32'd0);

    // R4 add/sub wrap
    clear_prog();
    prog[0] = enc(3, 1, 0, 0, -1);
    prog[1] = enc(3, 2, 0, 0, 1);
    prog[2] = enc(1, 3, 1, 2, 0);
    prog[3] = enc(2, 4, 0, 2, 0);
    prog[4] = enc(2, 5, 2, 1, 0);
    load_and_reset();
    run(6, "R4");
    peek_reg(3, v); chk("R4", "add wrap", v, 32'd0);
    peek_reg(4, v); chk("R4", "sub wrap", v, 32'hFFFFFFFF);
    peek_reg(5, v); chk("R4", "sub", v, 32'd2);

    // R6 / R7 store and load with address truncation and negative offset
    clear_prog();
    prog[0] = enc(3, 1, 0, 0, 300);
    prog[1] = enc(3, 2, 0, 0, 77);
    prog[2] = enc(5, 9, 1, 2, -40);
    prog[3] = enc(4, 3, 0, 0, 4);
    prog[4] = enc(4, 4, 0, 0, 5);
    prog[5] = enc(5, 0, 0, 1, 255);
    prog[6] = enc(4, 5, 1, 0, -45);
    load_and_reset();
    run(8, "R6");
    peek_mem(4, v);   chk("R6", "mem[4]", v, 32'd77);
    peek_mem(255, v); chk("R6", "mem[255]", v, 32'd300);
    peek_reg(9, v);   chk("R6", "store rd untouched", v, 32'd0);
    peek_reg(3, v);   chk("R7", "x3 load", v, 32'd77);
    peek_reg(4, v);   chk("R7", "x4 unwritten word", v, 32'd0);
    peek_reg(5, v);   chk("R7", "x5 wrap load", v, 32'd300);

    // R9 undefined operations change nothing; R1 memory cleared by reset
    clear_prog();
    prog[0] = enc(3, 1, 0, 0, 9);
    prog[1] = enc(6, 1, 1, 1, 5);
    prog[2] = enc(63, 1, 1, 1, -3);
    prog[3] = enc(17, 2, 1, 1, 0);
    prog[4] = enc(0, 3, 1, 1, 1);
    load_and_reset();
    peek_mem(4, v); chk("R1", "mem cleared by reset", v, 32'd0);
    run(6, "R9");
    peek_reg(1, v); chk("R9", "x1 kept", v, 32'd9);
    peek_reg(2, v); chk("R9", "x2 kept", v, 32'd0);

    // R12 random mix over more than 256 cycles so the counter wraps (R8)
    for (int i = 0; i < 256; i++) begin
      int op, imm;
      if ($urandom_range(9) == 0) op = int'($urandom_range(63, 6));
      else op = int'($urandom_range(5));
      if (op == 4 || op == 5) imm = int'($urandom_range(127)) - 64;
      else imm = int'($urandom_range(16383)) - 8192;
      prog[i] = enc(op, int'($urandom_range(15)), int'($urandom_range(15)),
                    int'($urandom_range(15)), imm);
    end
    load_and_reset();
    run(300, "R12");
    chk("R8", "pc after wrap", {24'd0, pc_o}, 32'd44);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule